// File: doc/BRIEF.md
# Graded-Membership Toggle Register

This block is a clocked register that stores one quantized fuzzy membership value, an unsigned code from 0 up to a full-scale code that stands for logic one. A graded toggle input drives the update. In place of an XOR, the next state is built from fuzzy AND (minimum), fuzzy OR (maximum) and complement (full scale minus the value). Two dual equations are available, and a select input picks one of them. The first is a maximum of two minimums: max(min(~T,Q), min(T,~Q)). The second is a minimum of two maximums: min(max(T,Q), max(~T,~Q)).

When T and Q are at the binary extremes, the register works as an ordinary toggle flip-flop. At intermediate toggle codes, a stored value can settle at a fixed point or swing between two codes from one enabled cycle to the next. The combinational next state is brought out on its own port, so neighbouring fuzzy logic can use it without waiting a cycle. A synchronous clear, a preset load and a clock enable let the register be used as a fuzzy memory element inside a larger sequential datapath.

Top module: `fuzzy_tff`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, and after it is released, `q` reads 0 until the first update takes effect.
- R2: With `form_sel`=0, `q_next` equals max(min(FULL−T, Q), min(T, FULL−Q)) for the current `q` and the toggle code T.
- R3: With `form_sel`=1, `q_next` equals min(max(T, Q), max(FULL−T, FULL−Q)).
- R4: Complement means FULL minus the code. Any `tgl` or `preset` code above FULL is treated as FULL, and `q` and `q_next` never exceed FULL.
- R5: At T=0 both forms hold `q`. At T=FULL both forms give FULL−`q`. At these extremes the two forms always agree.
- R6: `q` changes only on a rising clock edge. While `en` is 0 and `clr` is 0, `q` keeps its value whatever `tgl`, `form_sel`, `load` and `preset` do.
- R7: `clr`=1 sets `q` to 0 at the next rising edge. It takes priority over `load` and works regardless of `en`.
- R8: With `en`=1, `load`=1 and `clr`=0, the next edge stores the saturated `preset` and the toggle update is skipped. With `en`=1, `load`=0 and `clr`=0, the next edge stores `q_next`.
- R9: Pulling `rst_n` low clears `q` without waiting for a clock edge. After `rst_n` rises, the register first accepts an update on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Synchronous clear of the stored value |
| en | input | 1 | Clock enable for load and toggle updates |
| form_sel | input | 1 | 0: max-of-mins equation, 1: min-of-maxes equation |
| load | input | 1 | Store `preset` instead of the toggle result |
| preset | input | WIDTH | Preset membership code |
| tgl | input | WIDTH | Graded toggle code T |
| q | output | WIDTH | Stored membership code |
| q_next | output | WIDTH | Combinational next state of the selected equation |

## Verification
Both equations are driven with random pairs of stored value and toggle code, including toggle codes above full scale, and each result is compared with an independent model. This separates the two forms and shows whether saturation and complement are right. Directed patterns at T=0 and T=FULL, taken over several stored values, show whether the register behaves as a binary toggle and whether the two forms agree there. Multi-cycle runs from Q=0 with a low intermediate toggle code (the value settles) and a high one (the value alternates) exercise the feedback path through the register. Further patterns cover clear, load and enable priority, and the timing of the asynchronous reset and its release.

// File: rtl/fzt_pkg.sv
package fzt_pkg;

  typedef enum logic {
    FORM_SOP = 1'b0,
    FORM_POS = 1'b1
  } fzt_form_e;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_CLR  = 2'd1,
    UPD_LOAD = 2'd2,
    UPD_TGL  = 2'd3
  } fzt_upd_e;

endpackage

// File: rtl/fzt_rst_sync.sv
module fzt_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/fzt_clamp.sv
module fzt_clamp #(
  parameter int WIDTH = 8,
  parameter int FULL  = 200
) (
  input  logic [WIDTH-1:0] code_in,
  output logic [WIDTH-1:0] code_out
);

  localparam logic [WIDTH-1:0] FULL_C = FULL[WIDTH-1:0];

  always_comb begin
    if (code_in > FULL_C) code_out = FULL_C;
    else                  code_out = code_in;
  end

endmodule

// File: rtl/fzt_gate_net.sv
module fzt_gate_net
  import fzt_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int FULL  = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fzt_form_e        form,
  input  logic [WIDTH-1:0] t_in,
  input  logic [WIDTH-1:0] q_in,
  output logic [WIDTH-1:0] q_nxt
);

  localparam int NFORMS = 2;
  localparam logic [WIDTH-1:0] FULL_C = FULL[WIDTH-1:0];

  function automatic logic [WIDTH-1:0] f_min(input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [WIDTH-1:0] f_max(input logic [WIDTH-1:0] a,
                                             input logic [WIDTH-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [WIDTH-1:0] t_neg;
  logic [WIDTH-1:0] q_neg;
  logic [WIDTH-1:0] cand [NFORMS];

  // complement against full scale; inputs are already saturated
  assign t_neg = FULL_C - t_in;
  assign q_neg = FULL_C - q_in;

  for (genvar f = 0; f < NFORMS; f++) begin : g_form
    if (f == 0) begin : g_sop
      logic [WIDTH-1:0] keep_term;
      logic [WIDTH-1:0] flip_term;
      always_comb begin
        keep_term = f_min(t_neg, q_in);
        flip_term = f_min(t_in, q_neg);
        cand[f]   = f_max(keep_term, flip_term);
      end
    end else begin : g_pos
      logic [WIDTH-1:0] up_term;
      logic [WIDTH-1:0] dn_term;
      always_comb begin
        up_term = f_max(t_in, q_in);
        dn_term = f_max(t_neg, q_neg);
        cand[f] = f_min(up_term, dn_term);
      end
    end
  end

  always_comb begin
    unique case (form)
      FORM_SOP: q_nxt = cand[0];
      FORM_POS: q_nxt = cand[1];
      default:  q_nxt = cand[0];
    endcase
  end

  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_nxt <= FULL_C);
  p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_in == '0) |-> (q_nxt == q_in));
  p_full_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_in == FULL_C) |-> (q_nxt == FULL_C - q_in));
  p_forms_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((t_in == '0) || (t_in == FULL_C)) |-> (cand[0] == cand[1]));

endmodule

// File: rtl/fzt_state_reg.sv
module fzt_state_reg
  import fzt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] preset_val,
  input  logic [WIDTH-1:0] tgl_next,
  output logic [WIDTH-1:0] q
);

  fzt_upd_e         upd;
  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] q_r;

  always_comb begin
    if (clr)       upd = UPD_CLR;
    else if (!en)  upd = UPD_HOLD;
    else if (load) upd = UPD_LOAD;
    else           upd = UPD_TGL;
  end

  always_comb begin
    unique case (upd)
      UPD_CLR:  q_d = '0;
      UPD_LOAD: q_d = preset_val;
      UPD_TGL:  q_d = tgl_next;
      default:  q_d = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(q));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && load && !clr) |=> (q == $past(preset_val)));
  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !clr) |=> (q == $past(tgl_next)));

endmodule

// File: rtl/fuzzy_tff.sv
module fuzzy_tff
  import fzt_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int FULL  = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             form_sel,
  input  logic             load,
  input  logic [WIDTH-1:0] preset,
  input  logic [WIDTH-1:0] tgl,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_next
);

  logic             rst_n_s;
  logic [WIDTH-1:0] tgl_c;
  logic [WIDTH-1:0] preset_c;
  fzt_form_e        form;

  assign form = fzt_form_e'(form_sel);

  fzt_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  fzt_clamp #(.WIDTH(WIDTH), .FULL(FULL)) u_clamp_t (
    .code_in  (tgl),
    .code_out (tgl_c)
  );

  fzt_clamp #(.WIDTH(WIDTH), .FULL(FULL)) u_clamp_p (
    .code_in  (preset),
    .code_out (preset_c)
  );

  fzt_gate_net #(.WIDTH(WIDTH), .FULL(FULL)) u_gates (
    .clk   (clk),
    .rst_n (rst_n_s),
    .form  (form),
    .t_in  (tgl_c),
    .q_in  (q),
    .q_nxt (q_next)
  );

  fzt_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr        (clr),
    .en         (en),
    .load       (load),
    .preset_val (preset_c),
    .tgl_next   (q_next),
    .q          (q)
  );

endmodule

// File: tb/sim_fuzzy_tff.sv
module sim_fuzzy_tff;

  localparam int W    = 8;
  localparam int FULL = 200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         en = 1'b0;
  logic         form_sel = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] tgl = '0;
  logic [W-1:0] q;
  logic [W-1:0] q_next;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  fuzzy_tff #(.WIDTH(W), .FULL(FULL)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .form_sel(form_sel),
    .load(load), .preset(preset), .tgl(tgl), .q(q), .q_next(q_next)
  );

  function automatic int sat(int x);
    return (x > FULL) ? FULL : x;
  endfunction
  function automatic int mn(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  function automatic int ref_next(bit sel, int t, int qv);
    int tt = sat(t);
    int nt = FULL - tt;
    int nq = FULL - qv;
    if (!sel) return mx(mn(nt, qv), mn(tt, nq));
    return mn(mx(tt, qv), mx(nt, nq));
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put_q(int v);
    en = 1'b1; load = 1'b1; preset = W'(v);
    tick();
    load = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    check("R1 q in reset", int'(q), 0);
    rst_n = 1'b1;
    en = 1'b0;
    repeat (3) tick();
    check("R1 q after release", int'(q), 0);
    form_sel = 1'b0; tgl = 8'd0; #1;
    check("R1 q_next from zero state", int'(q_next), 0);
  endtask

  task automatic t_form(bit sel);
    for (int i = 0; i < 40; i++) begin
      int q0 = $urandom_range(0, FULL);
      int t0 = $urandom_range(0, 255);
      int e;
      put_q(q0);
      form_sel = sel; tgl = W'(t0); #1;
      e = ref_next(sel, t0, q0);
      check(sel ? "R3 q_next pos form" : "R2 q_next sop form", int'(q_next), e);
      tick();
      check(sel ? "R3 q after edge" : "R8 q after toggle edge", int'(q), e);
    end
  endtask

  task automatic t_saturate();
    put_q(60);
    form_sel = 1'b0; tgl = 8'd255; #1;
    check("R4 over-range tgl acts as full", int'(q_next), FULL - 60);
    form_sel = 1'b1; tgl = 8'd230; #1;
    check("R4 over-range tgl pos form", int'(q_next), FULL - 60);
    put_q(250);
    check("R4 over-range preset saturates", int'(q), FULL);
  endtask

  task automatic t_extremes();
    int vals[4] = '{0, FULL, 37, 163};
    foreach (vals[k]) begin
      for (int s = 0; s < 2; s++) begin
        put_q(vals[k]);
        form_sel = s[0]; tgl = 8'd0; #1;
        check("R5 T=0 holds", int'(q_next), vals[k]);
        tgl = W'(FULL); #1;
        check("R5 T=FULL inverts", int'(q_next), FULL - vals[k]);
      end
    end
    put_q(0);
    form_sel = 1'b0; tgl = W'(FULL);
    tick(); check("R5 binary toggle to one", int'(q), FULL);
    form_sel = 1'b1;
    tick(); check("R5 binary toggle back to zero", int'(q), 0);
  endtask

  task automatic t_enable();
    put_q(90);
    en = 1'b0; tgl = 8'd120; form_sel = 1'b0; load = 1'b1; preset = 8'd11;
    repeat (3) tick();
    check("R6 en low holds q", int'(q), 90);
    load = 1'b0; en = 1'b1;
    #3;
    check("R6 no change between edges", int'(q), 90);
  endtask

  task automatic t_clear();
    put_q(140);
    clr = 1'b1; en = 1'b0;
    tick();
    check("R7 clr with en low", int'(q), 0);
    put_q(140);
    clr = 1'b1; en = 1'b1; load = 1'b1; preset = 8'd99;
    tick();
    check("R7 clr beats load", int'(q), 0);
    clr = 1'b0; load = 1'b0;
  endtask

  task automatic t_load();
    put_q(30);
    en = 1'b1; load = 1'b1; preset = 8'd170; tgl = W'(FULL); form_sel = 1'b0;
    tick();
    check("R8 load overrides toggle", int'(q), 170);
    load = 1'b0;
    tick();
    check("R8 toggle after load", int'(q), FULL - 170);
  endtask

  task automatic t_sequences();
    for (int s = 0; s < 2; s++) begin
      int cur;
      put_q(0);
      form_sel = s[0]; tgl = 8'd80; cur = 0;
      for (int k = 0; k < 4; k++) begin
        tick(); cur = ref_next(s[0], 80, cur);
        check("R2 settling run", int'(q), cur);
      end
      check("R3 settles at T", int'(q), 80);
      $display("run form=%0d T=80 settled at q=%0d", s, q);
      put_q(0);
      tgl = 8'd150; cur = 0;
      for (int k = 0; k < 5; k++) begin
        tick(); cur = ref_next(s[0], 150, cur);
        check("R3 alternating run", int'(q), cur);
        $display("run form=%0d T=150 step=%0d q=%0d", s, k, q);
      end
      check("R2 alternation odd step", int'(q), 150);
      tick();
      check("R2 alternation even step", int'(q), 50);
    end
  endtask

  task automatic t_async();
    put_q(120);
    @(negedge clk); #2;
    rst_n = 1'b0; #1;
    check("R9 async clear without edge", int'(q), 0);
    @(negedge clk);
    en = 1'b1; load = 1'b1; preset = 8'd77;
    rst_n = 1'b1;
    tick(); check("R9 first edge after release", int'(q), 0);
    tick(); check("R9 second edge after release", int'(q), 0);
    tick(); check("R9 third edge loads", int'(q), 77);
    load = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_form(1'b0);
    t_form(1'b1);
    t_saturate();
    t_extremes();
    t_enable();
    t_clear();
    t_load();
    t_sequences();
    t_async();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule